// File: doc/BRIEF.md
# Timestamped Signal Change Logger

A debug block that watches a vector of related design signals, all already in its clock domain, and writes an event into a small on-chip FIFO on every clock where any bit of the vector differs from its value on the clock before. Each event holds a cycle count and the new vector value. The block stores only the cycles where something moved, so a modest FIFO can hold events spread over seconds of run time. After the run, an operator sends one-byte commands over a UART and the block replies with the stored events.

The block comes out of reset disarmed: nothing is recorded until `arm_clr` is pulsed or a clear command arrives. Arming empties the FIFO, clears the overflow flag, restarts the timestamp at zero and loads the previous-value register with the current vector, so arming never creates an event by itself. When the FIFO is full, later changes are dropped and a sticky overflow flag is set. The earliest events are kept.

A readout is run by a state machine with these states: `ST_IDLE` (capture runs and commands are accepted), `ST_HDR_GO` (the header byte is started), `ST_HDR_WAIT` (the header is on the line), `ST_LOAD` (the oldest entry is popped into a shift register), `ST_BYTE_GO` (one entry byte is started) and `ST_BYTE_WAIT` (that byte is on the line). The transitions are:
- `ST_IDLE` goes to `ST_HDR_GO` when the read command arrives.
- `ST_HDR_GO` goes to `ST_HDR_WAIT`, and `ST_BYTE_GO` goes to `ST_BYTE_WAIT`, as soon as the transmitter is free.
- `ST_HDR_WAIT` goes to `ST_LOAD` when the transmitter is done and entries remain, or back to `ST_IDLE` when none remain.
- `ST_LOAD` always goes to `ST_BYTE_GO`.
- `ST_BYTE_WAIT` goes back to `ST_BYTE_GO` for the next byte of the same entry. After the last byte of an entry it goes to `ST_LOAD` if entries remain, or to `ST_IDLE` if none remain.

Top module: `sig_change_logger`

## Requirements
- R1: After reset, `uart_tx` is high, the logger is disarmed and the FIFO is empty. Vector changes made before the first arm are not recorded, so a read returns header 0x00 and no entries.
- R2: A one-cycle pulse on `arm_clr` arms the logger. It empties the FIFO, clears overflow and restarts the timestamp at zero. A vector that differs from its pre-arm value at the arm clock does not produce an event.
- R3: While armed and idle, an event is stored on exactly those clocks where `mon_vec` differs from its value on the previous clock. A vector held steady stores nothing.
- R4: Each entry is {timestamp, vector} with the timestamp in the upper TS_W bits. An event sampled at the k-th clock after the arm clock carries timestamp k-1.
- R5: When DEPTH entries are stored, further changes are dropped, the first DEPTH entries are kept, and the overflow flag is set. The overflow flag stays set until the next arm, even across reads.
- R6: The UART frames are 8N1. Each frame has a low start bit, eight data bits sent LSB first, and a high stop bit. Every bit lasts BAUD_DIV clocks, and the line idles high.
- R7: Receiving byte 0x52 in idle sends a header byte followed by all stored entries, oldest first. The header has the overflow flag in bit 7 and the entry count, saturated at 127, in bits 6:0. Each entry is sent as ceil((TS_W+VEC_W)/8) bytes, most significant byte first, zero-padded at the top. A read empties the FIFO.
- R8: Receiving byte 0x43 in idle has the same effect as an `arm_clr` pulse. It sends nothing.
- R9: Capture is suspended from the read command until the last byte is sent. Vector changes during a read are not stored, and the vector value reached during the read does not create an event afterwards.
- R10: Any other received byte is ignored. Nothing is transmitted and the stored entries are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logger clock; the monitored vector is synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_clr | input | 1 | One-cycle pulse: empty FIFO, clear overflow, zero timestamp, arm |
| mon_vec | input | VEC_W | Concatenated signals being watched |
| uart_rx | input | 1 | Serial command input, 8N1 |
| uart_tx | output | 1 | Serial dump output, 8N1 |

## Verification
The bench uses VEC_W=8, TS_W=32, DEPTH=4 and BAUD_DIV=8. With these values a 40-bit entry takes five bytes, and a whole dump with the header fits in a few thousand clocks. With only four FIFO slots, six changes are enough to overflow it, so the dropped events and the 0x84 header can be checked directly. Short bit times also make it possible to change the vector in the middle of a dump and to watch the line stay quiet after an unknown command.

// File: rtl/scl_pkg.sv
package scl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HDR_GO,
        ST_HDR_WAIT,
        ST_LOAD,
        ST_BYTE_GO,
        ST_BYTE_WAIT
    } dump_st_t;

    localparam logic [7:0] CMD_READ  = 8'h52;
    localparam logic [7:0] CMD_CLEAR = 8'h43;
endpackage

// File: rtl/scl_uart_tx.sv
module scl_uart_tx #(
    parameter int BAUD_DIV = 434
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] data,
    output logic       busy,
    output logic       txd
);
    localparam int DIV_W = $clog2(BAUD_DIV + 1);

    logic [9:0]       sh;
    logic [3:0]       nbit;
    logic [DIV_W-1:0] bcnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '1;
            nbit <= '0;
            bcnt <= '0;
            busy <= 1'b0;
        end else if (start && !busy) begin
            sh   <= {1'b1, data, 1'b0};
            nbit <= '0;
            bcnt <= '0;
            busy <= 1'b1;
        end else if (busy) begin
            if (bcnt == DIV_W'(BAUD_DIV - 1)) begin
                bcnt <= '0;
                sh   <= {1'b1, sh[9:1]};
                if (nbit == 4'd9) busy <= 1'b0;
                else              nbit <= nbit + 4'd1;
            end else begin
                bcnt <= bcnt + DIV_W'(1);
            end
        end
    end

    assign txd = sh[0];

    // R6: line idles high and every frame opens with a low start bit
    a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);
    a_r6_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);
endmodule

// File: rtl/scl_uart_rx.sv
module scl_uart_rx #(
    parameter int BAUD_DIV = 434
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd,
    output logic       valid,
    output logic [7:0] data
);
    localparam int DIV_W = $clog2(BAUD_DIV + 1);

    logic [1:0]       sync;
    logic             active;
    logic [3:0]       nbit;
    logic [DIV_W-1:0] cnt;
    logic             rx_s;

    assign rx_s = sync[1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync   <= 2'b11;
            active <= 1'b0;
            nbit   <= '0;
            cnt    <= '0;
            data   <= '0;
            valid  <= 1'b0;
        end else begin
            sync  <= {sync[0], rxd};
            valid <= 1'b0;
            if (!active) begin
                if (!rx_s) begin
                    active <= 1'b1;
                    nbit   <= '0;
                    cnt    <= DIV_W'(BAUD_DIV / 2);
                end
            end else if (cnt != '0) begin
                cnt <= cnt - DIV_W'(1);
            end else begin
                cnt <= DIV_W'(BAUD_DIV - 1);
                if (nbit == 4'd0) begin
                    if (rx_s) active <= 1'b0;
                    else      nbit   <= 4'd1;
                end else if (nbit == 4'd9) begin
                    valid  <= rx_s;
                    active <= 1'b0;
                end else begin
                    data <= {rx_s, data[7:1]};
                    nbit <= nbit + 4'd1;
                end
            end
        end
    end
endmodule

// File: rtl/scl_event_fifo.sv
module scl_event_fifo #(
    parameter int W     = 40,
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] count,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && (count != '0);
    assign dout    = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
            if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
            if (do_push && !do_pop)      count <= count + CW'(1);
            else if (do_pop && !do_push) count <= count - CW'(1);
        end
    end

    // R5: occupancy never passes the depth
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R7: a read pop removes exactly one entry
    a_r7_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && count != '0 && !push && !clr) |=> (count == $past(count) - CW'(1)));
endmodule

// File: rtl/sig_change_logger.sv
module sig_change_logger
    import scl_pkg::*;
#(
    parameter int VEC_W    = 8,
    parameter int TS_W     = 32,
    parameter int DEPTH    = 16,
    parameter int BAUD_DIV = 434
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_clr,
    input  logic [VEC_W-1:0] mon_vec,
    input  logic             uart_rx,
    output logic             uart_tx
);
    localparam int ENT_W = TS_W + VEC_W;
    localparam int ENT_B = (ENT_W + 7) / 8;
    localparam int PAD_W = ENT_B * 8;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int BI_W  = $clog2(ENT_B + 1);

    dump_st_t          state, nxt;
    logic              armed, ovf;
    logic [VEC_W-1:0]  prev;
    logic [TS_W-1:0]   ts;
    logic [PAD_W-1:0]  shift;
    logic [BI_W-1:0]   bidx;
    logic              rx_valid, tx_busy, tx_start, pop;
    logic [7:0]        rx_data, tx_data, hdr;
    logic [ENT_W-1:0]  fifo_out;
    logic [CNT_W-1:0]  cnt;
    logic              full, arm_req, changed, cap_en, push, drop;
    logic [6:0]        cnt7;

    scl_uart_rx #(.BAUD_DIV(BAUD_DIV)) u_rx (
        .clk(clk), .rst_n(rst_n), .rxd(uart_rx), .valid(rx_valid), .data(rx_data));

    scl_uart_tx #(.BAUD_DIV(BAUD_DIV)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(tx_start), .data(tx_data),
        .busy(tx_busy), .txd(uart_tx));

    scl_event_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(arm_req), .push(push), .din({ts, mon_vec}),
        .pop(pop), .dout(fifo_out), .count(cnt), .full(full));

    // capture path
    assign arm_req = arm_clr || (state == ST_IDLE && rx_valid && rx_data == CMD_CLEAR);
    assign changed = armed && (mon_vec != prev);
    assign cap_en  = armed && (state == ST_IDLE) && !arm_req;
    assign push    = cap_en && changed && !full;
    assign drop    = cap_en && changed && full;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            ovf   <= 1'b0;
            prev  <= '0;
            ts    <= '0;
        end else if (arm_req) begin
            armed <= 1'b1;
            ovf   <= 1'b0;
            prev  <= mon_vec;
            ts    <= '0;
        end else if (armed) begin
            prev <= mon_vec;
            ts   <= ts + TS_W'(1);
            if (drop) ovf <= 1'b1;
        end
    end

    // header byte
    always_comb begin
        if (32'(cnt) > 32'd127) cnt7 = 7'h7F;
        else                    cnt7 = 7'(cnt);
        hdr = {ovf, cnt7};
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (rx_valid && rx_data == CMD_READ) nxt = ST_HDR_GO;
            ST_HDR_GO:    if (!tx_busy) nxt = ST_HDR_WAIT;
            ST_HDR_WAIT:  if (!tx_busy) nxt = (cnt == '0) ? ST_IDLE : ST_LOAD;
            ST_LOAD:      nxt = ST_BYTE_GO;
            ST_BYTE_GO:   if (!tx_busy) nxt = ST_BYTE_WAIT;
            ST_BYTE_WAIT: if (!tx_busy) begin
                if (bidx != BI_W'(ENT_B - 1)) nxt = ST_BYTE_GO;
                else                          nxt = (cnt == '0) ? ST_IDLE : ST_LOAD;
            end
            default:      nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        tx_start = 1'b0;
        tx_data  = shift[PAD_W-1 -: 8];
        pop      = 1'b0;
        unique case (state)
            ST_HDR_GO:  begin tx_start = !tx_busy; tx_data = hdr; end
            ST_LOAD:    pop = 1'b1;
            ST_BYTE_GO: tx_start = !tx_busy;
            default:    ;
        endcase
    end

    // entry shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift <= '0;
            bidx  <= '0;
        end else if (state == ST_LOAD) begin
            shift <= PAD_W'(fifo_out);
            bidx  <= '0;
        end else if (state == ST_BYTE_WAIT && !tx_busy) begin
            shift <= shift << 8;
            bidx  <= bidx + BI_W'(1);
        end
    end

    // R2: arming restarts the timestamp and clears overflow
    a_r2_arm_restart: assert property (@(posedge clk) disable iff (!rst_n)
        arm_clr |=> (ts == '0 && !ovf && armed));
    // R5: overflow stays set until re-armed
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !arm_req) |=> ovf);
    // R9: nothing is added to the FIFO while a dump runs
    a_r9_no_fill_in_dump: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> (cnt <= $past(cnt)));
    // R1: disarmed logger never stores
    a_r1_disarmed_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !arm_req) |=> (cnt == '0));
endmodule

// File: tb/sig_change_logger_bench.sv
`timescale 1ns/1ps
module sig_change_logger_bench;
    localparam int VEC_W = 8;
    localparam int TS_W  = 32;
    localparam int DEPTH = 4;
    localparam int BAUD  = 8;
    localparam int ENT_B = (TS_W + VEC_W + 7) / 8;
    localparam int BITNS = BAUD * 20;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             arm_clr = 1'b0;
    logic [VEC_W-1:0] mon_vec = '0;
    logic             uart_rx = 1'b1;
    logic             uart_tx;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int a0 = 0;
    int falls = 0;
    int n_exp = 0;
    int          exp_ts [8];
    logic [7:0]  exp_v  [8];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge uart_tx) falls <= falls + 1;

    sig_change_logger #(.VEC_W(VEC_W), .TS_W(TS_W), .DEPTH(DEPTH), .BAUD_DIV(BAUD)) u_sig_change_logger (
        .clk(clk), .rst_n(rst_n), .arm_clr(arm_clr), .mon_vec(mon_vec),
        .uart_rx(uart_rx), .uart_tx(uart_tx));

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_arm();
        @(negedge clk);
        arm_clr = 1'b1;
        a0 = cyc;
        @(negedge clk);
        arm_clr = 1'b0;
        n_exp = 0;
    endtask

    task automatic change(input logic [7:0] v, input bit rec);
        @(negedge clk);
        mon_vec = v;
        if (rec) begin
            exp_ts[n_exp] = cyc - a0 - 1;
            exp_v[n_exp]  = v;
            n_exp++;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        uart_rx = 1'b0;
        repeat (BAUD) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            uart_rx = b[i];
            repeat (BAUD) @(negedge clk);
        end
        uart_rx = 1'b1;
        repeat (BAUD) @(negedge clk);
    endtask

    task automatic recv_byte(output logic [7:0] b);
        @(negedge uart_tx);
        #(BITNS * 3 / 2);
        for (int i = 0; i < 8; i++) begin
            b[i] = uart_tx;
            #(BITNS);
        end
        check(uart_tx === 1'b1, "R6 stop bit", {63'd0, uart_tx}, 64'd1);
    endtask

    task automatic get_dump(input logic [7:0] hdr_exp, input bit rel, input string tag);
        logic [7:0]  b;
        logic [39:0] ent;
        int          base;
        base = 0;
        fork
            send_byte(8'h52);
            begin
                recv_byte(b);
                check(b == hdr_exp, {tag, " R7 header"}, b, hdr_exp);
                for (int e = 0; e < int'(hdr_exp[6:0]); e++) begin
                    ent = '0;
                    for (int k = 0; k < ENT_B; k++) begin
                        recv_byte(b);
                        ent = {ent[31:0], b};
                    end
                    check(ent[7:0] == exp_v[e], {tag, " R4 vector"}, ent[7:0], exp_v[e]);
                    if (e == 0) base = int'(ent[39:8]);
                    if (rel)
                        check(int'(ent[39:8]) - base == exp_ts[e] - exp_ts[0], {tag, " R4 ts gap"},
                              ent[39:8] - base, exp_ts[e] - exp_ts[0]);
                    else
                        check(int'(ent[39:8]) == exp_ts[e], {tag, " R4 timestamp"}, ent[39:8], exp_ts[e]);
                end
            end
        join
        repeat (BAUD * 3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(uart_tx === 1'b1, "R1 R6 tx idle after reset", {63'd0, uart_tx}, 64'd1);
        change(8'h11, 1'b0);
        change(8'h22, 1'b0);
        repeat (4) @(negedge clk);
        get_dump(8'h00, 1'b0, "R1 disarmed");
    endtask

    task automatic t_basic();
        int f;
        change(8'h5A, 1'b0);
        do_arm();
        repeat (3) @(negedge clk);
        change(8'h5B, 1'b1);
        repeat (2) @(negedge clk);
        change(8'h13, 1'b1);
        change(8'h13, 1'b0);
        repeat (5) @(negedge clk);
        get_dump(8'h02, 1'b0, "R2 R3 basic");
        f = falls;
        get_dump(8'h00, 1'b0, "R7 emptied");
        check(falls == f + 1, "R7 empty dump is header only", falls - f, 1);
    endtask

    task automatic t_overflow();
        do_arm();
        for (int i = 0; i < 6; i++) begin
            change(8'(8'hA0 + i), n_exp < DEPTH);
            @(negedge clk);
        end
        repeat (3) @(negedge clk);
        get_dump(8'h84, 1'b0, "R5 overflow");
        get_dump(8'h80, 1'b0, "R5 sticky");
    endtask

    task automatic t_clear_cmd();
        int f;
        f = falls;
        send_byte(8'h43);
        repeat (BAUD * 4) @(negedge clk);
        check(falls == f, "R8 clear sends nothing", falls - f, 0);
        n_exp = 0;
        a0 = 0;
        change(8'hC1, 1'b1);
        repeat (3) @(negedge clk);
        change(8'hC2, 1'b1);
        repeat (3) @(negedge clk);
        get_dump(8'h02, 1'b1, "R8 clear");
    endtask

    task automatic t_ignore();
        int f;
        do_arm();
        change(8'h3C, 1'b1);
        repeat (2) @(negedge clk);
        f = falls;
        send_byte(8'h58);
        repeat (BAUD * 30) @(negedge clk);
        check(falls == f, "R10 no reply to unknown byte", falls - f, 0);
        check(uart_tx === 1'b1, "R10 line idle", {63'd0, uart_tx}, 64'd1);
        get_dump(8'h01, 1'b0, "R10 entries kept");
    endtask

    task automatic t_pause();
        do_arm();
        change(8'h77, 1'b1);
        repeat (2) @(negedge clk);
        fork
            get_dump(8'h01, 1'b0, "R9 dump");
            begin
                @(negedge uart_tx);
                for (int i = 0; i < 5; i++) begin
                    @(negedge clk);
                    mon_vec = 8'(8'h80 + i);
                    repeat (3) @(negedge clk);
                end
            end
        join
        repeat (5) @(negedge clk);
        get_dump(8'h00, 1'b0, "R9 paused");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        t_basic();
        t_overflow();
        t_clear_cmd();
        t_ignore();
        t_pause();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule